// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-source state of an interrupt distributor: an enable bit, a pending bit, an active bit, an 8-bit priority and a trigger configuration for each of `NUM_IRQ` interrupt IDs. Software reaches it through a plain 32-bit word bus with a write strobe and a combinational read port. Enable and pending each have two windows. In the set window a 1 bit sets the state and in the clear window a 1 bit clears it. A 0 bit in either window changes nothing, so drivers can update one source without a read-modify-write.

Hardware interrupt lines enter through `irq_in`. Each line is registered once. Depending on its configuration it is treated as active-high level or as rising edge. The lowest `NUM_SGI` IDs are reserved for software-generated interrupts and ignore their hardware line. A downstream arbiter reads the pending, enabled, active and priority vectors. It returns acknowledge and end-of-interrupt pulses that move one ID from pending to active and then back to idle.

Top module: `intd_regbank`

## Requirements
- R1: Word 0x000 bit 0 is the global distributor enable. It is readable and writable, resets to 0, and is driven on `dist_en`. While it is 0, hardware lines neither latch edges nor present level pending.
- R2: The enable-set window starts at 0x100. ID n is bit n%32 of the word at 0x100 + (n/32)*4. Writing 1 to a bit sets that enable and writing 0 leaves it unchanged. Reads return the current enables, and all enables reset to 0.
- R3: The enable-clear window starts at 0x180 and uses the same bit mapping as R2. Writing 1 clears the enable and writing 0 leaves it unchanged. Reads return the current enables.
- R4: The pending-set window is at 0x200 and the pending-clear window at 0x280, both with the R2 mapping and the same rule that only 1 bits act. Reads of either window return the effective pending state.
- R5: The active window at 0x300 uses the R2 mapping and is read-only. Writes to it change nothing.
- R6: Priority is one byte per ID. ID n sits at bits 8*(n%4)+7 to 8*(n%4) of the word at 0x400 + (n/4)*4. Only the upper `PRIO_KEEP` bits are stored (bits 7:3 by default, so the largest value is 0xF8) and the other bits read 0. Priorities reset to 0, and 0 is the most urgent.
- R7: The configuration field is 2 bits per ID, at bits 2*(n%16)+1 to 2*(n%16) of the word at 0xC00 + (n/16)*4. Code 01 means level and code 11 means rising edge. IDs below `NUM_SGI` always read 10 and ignore writes. For other IDs bit 0 always reads 1, bit 1 is writable, and the field resets to 01.
- R8: For an edge-configured ID, a 0-to-1 change of the registered input sets pending. Pending then holds after the line falls, until it is acknowledged or cleared through 0x280.
- R9: For a level-configured ID, pending is high while the registered input is high and the ID is not active, and it drops one cycle after the line falls. A software pending-set holds pending regardless of the line.
- R10: Hardware lines of IDs below `NUM_SGI` never make those IDs pending. Only a pending-set write does.
- R11: An acknowledge pulse for ID n clears its latched pending and sets it active on the next cycle. An end-of-interrupt pulse for ID n clears active. When both name the same ID in the same cycle, the acknowledge wins.
- R12: A write to an unaligned address, to an unmapped offset, or to a word past the last implemented ID changes nothing. A read of such an address returns 0.
- R13: `pend_vec`, `en_vec`, `act_vec` and `prio_vec` always match what the register windows read back for every ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address, shared by the read and write ports |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_in | input | NUM_IRQ | Hardware interrupt lines |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_id | input | ID_W | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_id | input | ID_W | ID being completed |
| dist_en | output | 1 | Global distributor enable |
| pend_vec | output | NUM_IRQ | Effective pending per ID |
| en_vec | output | NUM_IRQ | Enable per ID |
| act_vec | output | NUM_IRQ | Active per ID |
| prio_vec | output | 8*NUM_IRQ | Priority byte per ID, with ID n at bits 8n+7:8n |

## Verification
The per-cell assertions check on every cycle that set and clear strobes take effect, that acknowledge and end-of-interrupt move the active bit, that a latched edge holds, and that stored priorities are masked. At the top level they check that the control bit follows its writes and that unmapped addresses read 0. The address-to-bit mapping of every window is shown only by the bench's scenarios. The same holds for level pending tracking the registered line, for SGI lines being ignored, and for the return of level pending after end-of-interrupt. The bench covers these with directed cases and with random bus traffic compared against its own model.

// File: rtl/intd_pkg.sv
package intd_pkg;

   // Decoded register window selected by a bus address
   typedef enum logic [3:0] {
      W_NONE, W_CTRL, W_ENS, W_ENC, W_PDS, W_PDC, W_ACT, W_PRI, W_CFG
   } win_e;

   // Window bases expressed as word indices (byte offset / 4)
   localparam int unsigned WB_ENS = 32'h040;
   localparam int unsigned WB_ENC = 32'h060;
   localparam int unsigned WB_PDS = 32'h080;
   localparam int unsigned WB_PDC = 32'h0A0;
   localparam int unsigned WB_ACT = 32'h0C0;
   localparam int unsigned WB_PRI = 32'h100;
   localparam int unsigned WB_CFG = 32'h300;

   // Fixed configuration code of a software-generated ID
   localparam logic [1:0] CFG_SGI = 2'b10;

endpackage

// File: rtl/intd_addr_dec.sv
module intd_addr_dec
   import intd_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_IRQ = 64
) (
   input  logic [ADDR_W-1:0] addr,
   output win_e              win,
   output logic [ADDR_W-3:0] idx
);
   localparam int IDXW      = ADDR_W - 2;
   localparam int EN_WORDS  = (NUM_IRQ + 31) / 32;
   localparam int PRI_WORDS = (NUM_IRQ + 3) / 4;
   localparam int CFG_WORDS = (NUM_IRQ + 15) / 16;

   generate
      if (ADDR_W < 12) begin : g_bad_aw
         $error("intd_addr_dec: ADDR_W must be at least 12");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > 1024) begin : g_bad_n
         $error("intd_addr_dec: NUM_IRQ must be 1..1024");
      end
   endgenerate

   always_comb begin
      int unsigned w;
      w   = 32'(addr[ADDR_W-1:2]);
      win = W_NONE;
      idx = '0;
      if (addr[1:0] == 2'b00) begin
         if (w == 0) begin
            win = W_CTRL;
         end else if (w >= WB_ENS && w < WB_ENS + EN_WORDS) begin
            win = W_ENS;  idx = IDXW'(w - WB_ENS);
         end else if (w >= WB_ENC && w < WB_ENC + EN_WORDS) begin
            win = W_ENC;  idx = IDXW'(w - WB_ENC);
         end else if (w >= WB_PDS && w < WB_PDS + EN_WORDS) begin
            win = W_PDS;  idx = IDXW'(w - WB_PDS);
         end else if (w >= WB_PDC && w < WB_PDC + EN_WORDS) begin
            win = W_PDC;  idx = IDXW'(w - WB_PDC);
         end else if (w >= WB_ACT && w < WB_ACT + EN_WORDS) begin
            win = W_ACT;  idx = IDXW'(w - WB_ACT);
         end else if (w >= WB_PRI && w < WB_PRI + PRI_WORDS) begin
            win = W_PRI;  idx = IDXW'(w - WB_PRI);
         end else if (w >= WB_CFG && w < WB_CFG + CFG_WORDS) begin
            win = W_CFG;  idx = IDXW'(w - WB_CFG);
         end
      end
   end

endmodule

// File: rtl/intd_src_cell.sv
module intd_src_cell #(
   parameter bit IS_SGI    = 1'b0,
   parameter int PRIO_KEEP = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_in,
   input  logic       glob_en,
   input  logic       en_set,
   input  logic       en_clr,
   input  logic       pd_set,
   input  logic       pd_clr,
   input  logic       ack_hit,
   input  logic       eoi_hit,
   input  logic       prio_we,
   input  logic [7:0] prio_wd,
   input  logic       cfg_we,
   input  logic [1:0] cfg_wd,
   output logic       enabled,
   output logic       pending,
   output logic       active,
   output logic [7:0] prio,
   output logic [1:0] cfg
);
   localparam logic [7:0] PMASK = 8'(8'hFF << (8 - PRIO_KEEP));

   generate
      if (PRIO_KEEP < 1 || PRIO_KEEP > 8) begin : g_bad_pk
         $error("intd_src_cell: PRIO_KEEP must be 1..8");
      end
   endgenerate

   logic irq_q, lat_q, en_q, act_q, edge_sel, rise, hw_set;
   logic [7:0] prio_q;
   logic unused_cfg;

   assign unused_cfg = ^{cfg_we, cfg_wd};

   // Trigger configuration: fixed for software IDs, one stored bit otherwise
   generate
      if (IS_SGI) begin : g_fixed
         assign edge_sel = 1'b1;
         assign cfg      = intd_pkg::CFG_SGI;
      end else begin : g_prog
         logic edge_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      edge_q <= 1'b0;
            else if (cfg_we) edge_q <= cfg_wd[1];
         end
         assign edge_sel = edge_q;
         assign cfg      = {edge_q, 1'b1};
      end
   endgenerate

   assign rise   = irq_in & ~irq_q;
   assign hw_set = !IS_SGI && edge_sel && rise && glob_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         lat_q  <= 1'b0;
         en_q   <= 1'b0;
         act_q  <= 1'b0;
         prio_q <= 8'h00;
      end else begin
         irq_q <= irq_in;
         lat_q <= (lat_q & ~(pd_clr | ack_hit)) | hw_set | pd_set;
         en_q  <= (en_q | en_set) & ~en_clr;
         act_q <= (act_q & ~eoi_hit) | ack_hit;
         if (prio_we) prio_q <= prio_wd & PMASK;
      end
   end

   assign enabled = en_q;
   assign active  = act_q;
   assign prio    = prio_q;
   assign pending = lat_q | (!IS_SGI && !edge_sel && irq_q && glob_en && !act_q);

   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> enabled);
   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !enabled);
   // R6
   prio_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prio_we |=> prio == ($past(prio_wd) & PMASK));
   // R8
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel && pending && !pd_clr && !ack_hit && !cfg_we |=> pending);
   // R11
   ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |=> active);
   // R11
   eoi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_hit && !ack_hit |=> !active);
   // R11
   act_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_hit && !active |=> !active);

endmodule

// File: rtl/intd_regbank.sv
module intd_regbank
   import intd_pkg::*;
#(
   parameter int NUM_IRQ   = 64,
   parameter int NUM_SGI   = 16,
   parameter int PRIO_KEEP = 5,
   parameter int ADDR_W    = 12,
   parameter int ID_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wr_data,
   output logic [31:0]          rd_data,
   input  logic [NUM_IRQ-1:0]   irq_in,
   input  logic                 ack_valid,
   input  logic [ID_W-1:0]      ack_id,
   input  logic                 eoi_valid,
   input  logic [ID_W-1:0]      eoi_id,
   output logic                 dist_en,
   output logic [NUM_IRQ-1:0]   pend_vec,
   output logic [NUM_IRQ-1:0]   en_vec,
   output logic [NUM_IRQ-1:0]   act_vec,
   output logic [8*NUM_IRQ-1:0] prio_vec
);
   generate
      if (NUM_SGI < 0 || NUM_SGI > NUM_IRQ) begin : g_bad_sgi
         $error("intd_regbank: NUM_SGI must be 0..NUM_IRQ");
      end
      if ((1 << ID_W) < NUM_IRQ) begin : g_bad_idw
         $error("intd_regbank: ID_W too narrow for NUM_IRQ");
      end
   endgenerate

   win_e              win;
   logic [ADDR_W-3:0] idx;
   logic              dist_q;
   logic [2*NUM_IRQ-1:0] cfg_vec;

   intd_addr_dec #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_dec (
      .addr (addr),
      .win  (win),
      .idx  (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       dist_q <= 1'b0;
      else if (wr_en && win == W_CTRL) dist_q <= wr_data[0];
   end
   assign dist_en = dist_q;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      logic hit32, hit4, hit16;
      assign hit32 = wr_en && (32'(idx) == 32'(i / 32));
      assign hit4  = wr_en && (win == W_PRI) && (32'(idx) == 32'(i / 4));
      assign hit16 = wr_en && (win == W_CFG) && (32'(idx) == 32'(i / 16));

      intd_src_cell #(.IS_SGI(i < NUM_SGI), .PRIO_KEEP(PRIO_KEEP)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .irq_in  (irq_in[i]),
         .glob_en (dist_q),
         .en_set  (hit32 && win == W_ENS && wr_data[i % 32]),
         .en_clr  (hit32 && win == W_ENC && wr_data[i % 32]),
         .pd_set  (hit32 && win == W_PDS && wr_data[i % 32]),
         .pd_clr  (hit32 && win == W_PDC && wr_data[i % 32]),
         .ack_hit (ack_valid && (32'(ack_id) == 32'(i))),
         .eoi_hit (eoi_valid && (32'(eoi_id) == 32'(i))),
         .prio_we (hit4),
         .prio_wd (wr_data[8*(i%4) +: 8]),
         .cfg_we  (hit16),
         .cfg_wd  (wr_data[2*(i%16) +: 2]),
         .enabled (en_vec[i]),
         .pending (pend_vec[i]),
         .active  (act_vec[i]),
         .prio    (prio_vec[8*i +: 8]),
         .cfg     (cfg_vec[2*i +: 2])
      );
   end

   // Read multiplexer: each ID drives its bits of the addressed word
   always_comb begin
      rd_data = '0;
      case (win)
         W_CTRL: rd_data[0] = dist_q;
         W_ENS, W_ENC:
            for (int i = 0; i < NUM_IRQ; i++)
               if (32'(idx) == 32'(i / 32)) rd_data[i % 32] = en_vec[i];
         W_PDS, W_PDC:
            for (int i = 0; i < NUM_IRQ; i++)
               if (32'(idx) == 32'(i / 32)) rd_data[i % 32] = pend_vec[i];
         W_ACT:
            for (int i = 0; i < NUM_IRQ; i++)
               if (32'(idx) == 32'(i / 32)) rd_data[i % 32] = act_vec[i];
         W_PRI:
            for (int i = 0; i < NUM_IRQ; i++)
               if (32'(idx) == 32'(i / 4)) rd_data[8*(i%4) +: 8] = prio_vec[8*i +: 8];
         W_CFG:
            for (int i = 0; i < NUM_IRQ; i++)
               if (32'(idx) == 32'(i / 16)) rd_data[2*(i%16) +: 2] = cfg_vec[2*i +: 2];
         default: rd_data = '0;
      endcase
   end

   // R1
   ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && win == W_CTRL |=> dist_en == $past(wr_data[0]));
   // R12
   rsv_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win == W_NONE |-> rd_data == 32'h0);

endmodule

// File: tb/tb_intd_regbank.sv
`timescale 1ns/1ps
module tb_intd_regbank;
   localparam int N  = 64;
   localparam int NS = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          wr_en = 0;
   logic [11:0]   addr = 0;
   logic [31:0]   wr_data = 0, rd_data;
   logic [N-1:0]  irq_in = '0;
   logic          ack_valid = 0, eoi_valid = 0;
   logic [5:0]    ack_id = 0, eoi_id = 0;
   logic          dist_en;
   logic [N-1:0]  pend_vec, en_vec, act_vec;
   logic [8*N-1:0] prio_vec;

   intd_regbank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .irq_in(irq_in), .ack_valid(ack_valid), .ack_id(ack_id),
      .eoi_valid(eoi_valid), .eoi_id(eoi_id), .dist_en(dist_en),
      .pend_vec(pend_vec), .en_vec(en_vec), .act_vec(act_vec), .prio_vec(prio_vec)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   bit en_m[N], lat_m[N], act_m[N], q_m[N], edg_m[N];
   logic [7:0] prio_m[N];
   bit dist_m = 0;

   function automatic bit is_edge(int i);
      return (i < NS) ? 1'b1 : edg_m[i];
   endfunction

   function automatic bit exp_pend(int i);
      return lat_m[i] | (!is_edge(i) & q_m[i] & dist_m & !act_m[i]);
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a);
      logic [31:0] r = 0;
      int w = int'(a[11:2]);
      if (a[1:0] != 0) return 0;
      if (w == 0) r[0] = dist_m;
      else if (w >= 'h40 && w < 'hE0) begin
         int grp = (w - 'h40) / 32;
         int k = (w - 'h40) % 32;
         for (int j = 0; j < 32; j++) begin
            int id = k * 32 + j;
            if (id < N) r[j] = (grp < 2) ? en_m[id] : (grp < 4) ? exp_pend(id) : act_m[id];
         end
      end else if (w >= 'h100 && w < 'h200) begin
         for (int b = 0; b < 4; b++) begin
            int id = (w - 'h100) * 4 + b;
            if (id < N) r[8*b +: 8] = prio_m[id];
         end
      end else if (w >= 'h300 && w < 'h340) begin
         for (int j = 0; j < 16; j++) begin
            int id = (w - 'h300) * 16 + j;
            if (id < N) r[2*j +: 2] = (id < NS) ? 2'b10 : {edg_m[id], 1'b1};
         end
      end
      return r;
   endfunction

   function automatic bit wbit(int base, int i);
      return wr_en && addr[1:0] == 0 && int'(addr[11:2]) == base + i / 32 && wr_data[i % 32];
   endfunction

   // Advance one clock and update the reference model from the held inputs
   task automatic step();
      bit dist_old;
      @(posedge clk);
      dist_old = dist_m;
      for (int i = 0; i < N; i++) begin
         bit hw  = (i >= NS) && is_edge(i) && irq_in[i] && !q_m[i] && dist_old;
         bit ack = ack_valid && int'(ack_id) == i;
         bit eoi = eoi_valid && int'(eoi_id) == i;
         lat_m[i] = (lat_m[i] & !(wbit('hA0, i) | ack)) | hw | wbit('h80, i);
         en_m[i]  = (en_m[i] | wbit('h40, i)) & !wbit('h60, i);
         act_m[i] = (act_m[i] & !eoi) | ack;
         q_m[i]   = irq_in[i];
      end
      if (wr_en && addr[1:0] == 0) begin
         int w = int'(addr[11:2]);
         if (w == 0) dist_m = wr_data[0];
         for (int i = 0; i < N; i++) begin
            if (w == 'h100 + i / 4) prio_m[i] = wr_data[8*(i%4) +: 8] & 8'hF8;
            if (w == 'h300 + i / 16 && i >= NS) edg_m[i] = wr_data[2*(i%16) + 1];
         end
      end
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rdc(string tag, logic [11:0] a);
      addr = a;
      #1;
      chk(tag, 64'(rd_data), 64'(exp_read(a)));
   endtask

   task automatic vec_chk(string tag);
      logic [N-1:0] ep, ee, ea;
      logic [8*N-1:0] pr;
      for (int i = 0; i < N; i++) begin
         ep[i] = exp_pend(i); ee[i] = en_m[i]; ea[i] = act_m[i];
         pr[8*i +: 8] = prio_m[i];
      end
      chk({tag, " pend"}, 64'(pend_vec), 64'(ep));
      chk({tag, " en"}, 64'(en_vec), 64'(ee));
      chk({tag, " act"}, 64'(act_vec), 64'(ea));
      for (int k = 0; k < 8; k++)
         chk({tag, " prio"}, prio_vec[64*k +: 64], pr[64*k +: 64]);
      chk({tag, " dist"}, 64'(dist_en), 64'(dist_m));
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      wr_en = 1; addr = a; wr_data = d;
      step();
      wr_en = 0;
   endtask

   task automatic ack(int id);
      ack_valid = 1; ack_id = 6'(id); step(); ack_valid = 0;
   endtask

   task automatic eoi(int id);
      eoi_valid = 1; eoi_id = 6'(id); step(); eoi_valid = 0;
   endtask

   function automatic logic [11:0] rand_addr();
      logic [11:0] bases [9] = '{12'h000, 12'h100, 12'h180, 12'h200, 12'h280,
                                 12'h300, 12'h400, 12'hC00, 12'h800};
      int b = $urandom % 9;
      int span = (b == 6) ? 20 : 4;
      logic [11:0] a = bases[b] + 12'(4 * ($urandom % span));
      if ($urandom % 16 == 0) a[1:0] = 2'($urandom);
      return a;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R13 watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < N; i++) prio_m[i] = 8'h00;
      repeat (3) @(negedge clk);
      vec_chk("R13 reset");
      rdc("R7 reset", 12'hC00);
      rdc("R7 reset", 12'hC08);
      rdc("R1 reset", 12'h000);
      rst_n = 1;
      @(negedge clk);

      // R1: global enable gates hardware capture
      irq_in[40] = 1; step(); step();
      chk("R1 gated", 64'(pend_vec[40]), 64'd0);
      wr(12'h000, 32'h1);
      chk("R1 enabled", 64'(pend_vec[40]), 64'd1);
      rdc("R1", 12'h000);
      // R9: level follows the line
      irq_in[40] = 0; step();
      chk("R9 level drop", 64'(pend_vec[40]), 64'd0);

      // R2 / R3
      wr(12'h104, 32'h5);
      chk("R2 set", 64'(en_vec[35:32]), 64'h5);
      wr(12'h104, 32'h0);
      chk("R2 zero ignored", 64'(en_vec[35:32]), 64'h5);
      rdc("R2", 12'h104);
      wr(12'h184, 32'h1);
      chk("R3 clear", 64'(en_vec[35:32]), 64'h4);
      rdc("R3", 12'h184);

      // R7 / R8: ID 41 to rising edge
      wr(12'hC08, 32'h5555_5555 | (32'h1 << 19));
      rdc("R7", 12'hC08);
      irq_in[41] = 1; step(); irq_in[41] = 0; step(); step();
      chk("R8 edge held", 64'(pend_vec[41]), 64'd1);
      wr(12'h284, 32'h1 << 9);
      chk("R4 clear", 64'(pend_vec[41]), 64'd0);
      irq_in[41] = 1; step(); irq_in[41] = 0; step();
      ack(41);
      chk("R11 ack pend", 64'(pend_vec[41]), 64'd0);
      chk("R11 ack act", 64'(act_vec[41]), 64'd1);
      eoi(41);
      chk("R11 eoi", 64'(act_vec[41]), 64'd0);

      // R11 with level source: pending returns after completion
      irq_in[40] = 1; step();
      ack(40);
      chk("R11 level ack", 64'(pend_vec[40]), 64'd0);
      eoi(40);
      chk("R11 level repend", 64'(pend_vec[40]), 64'd1);
      irq_in[40] = 0; step();

      // R10: software IDs ignore their lines
      irq_in[3] = 1; step(); irq_in[3] = 0; step();
      chk("R10 line ignored", 64'(pend_vec[3]), 64'd0);
      wr(12'h200, 32'h1 << 3);
      chk("R10 sw set", 64'(pend_vec[3]), 64'd1);
      rdc("R4", 12'h280);
      wr(12'h280, 32'h1 << 3);
      chk("R4 sw clear", 64'(pend_vec[3]), 64'd0);

      // R7: software IDs fixed, shared IDs keep bit 0
      wr(12'hC00, 32'h0);
      addr = 12'hC00; #1;
      chk("R7 sgi fixed", 64'(rd_data), 64'hAAAA_AAAA);
      wr(12'hC08, 32'h0);
      addr = 12'hC08; #1;
      chk("R7 shared", 64'(rd_data), 64'h5555_5555);

      // R6: priority masking
      wr(12'h400, 32'hFFFF_FFFF);
      addr = 12'h400; #1;
      chk("R6 mask", 64'(rd_data), 64'hF8F8_F8F8);
      wr(12'h43C, 32'h1234_5678);
      addr = 12'h43C; #1;
      chk("R6 bytes", 64'(rd_data), 64'h1030_5078);
      chk("R6 vec", 64'(prio_vec[8*63 +: 8]), 64'h10);

      // R5: active window is read-only
      ack(40);
      wr(12'h304, 32'h0);
      wr(12'h300, 32'hFFFF_FFFF);
      chk("R5 keep", 64'(act_vec[40]), 64'd1);
      chk("R5 no set", 64'(act_vec[31:0]), 64'd0);
      rdc("R5", 12'h304);
      eoi(40);

      // R12: reserved space
      wr(12'h004, 32'hFFFF_FFFF);
      addr = 12'h004; #1;
      chk("R12 rsv", 64'(rd_data), 64'd0);
      wr(12'h440, 32'hFFFF_FFFF);
      addr = 12'h440; #1;
      chk("R12 past prio", 64'(rd_data), 64'd0);
      wr(12'h101, 32'hFFFF_FFFF);
      chk("R12 unaligned", 64'(en_vec), 64'h0000_0004_0000_0000);
      rdc("R12", 12'h108);
      vec_chk("R13 directed");

      // Random traffic against the model
      for (int n = 0; n < 800; n++) begin
         irq_in = irq_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         ack_valid = ($urandom % 6 == 0); ack_id = 6'($urandom);
         eoi_valid = ($urandom % 5 == 0); eoi_id = 6'($urandom);
         if ($urandom % 3 == 0) begin
            wr_en = 1; addr = rand_addr(); wr_data = $urandom;
         end
         step();
         wr_en = 0; ack_valid = 0; eoi_valid = 0;
         vec_chk("R13");
         rdc("R4", rand_addr());
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule